// File: doc/BRIEF.md
# Dual-lane 64-bit integer ALU

This execution unit takes two 128-bit source vectors. Each vector holds four 32-bit components. Component k sits at bits [32k+31:32k], so x is component 0, y is 1, z is 2 and w is 3. The unit pairs the components into two independent 64-bit lanes. Lane 0 is built from x (low half) and y (high half), and lane 1 from z (low half) and w (high half). A single opcode is applied to both lanes in the same cycle.

Operands and opcode are registered together on the rising clock edge where `in_valid` is high. The 128-bit result and `out_valid` then appear one cycle later. The operation set covers:
- sign handling: absolute value, negate and set-sign
- wrapping add and multiply
- equality and ordered compares
- signed and unsigned min and max
- three kinds of shift
- widening of a 32-bit component to 64 bits

Top module: `vec64_alu`

## Requirements
- R1: Bits [63:0] of each vector form lane 0 and bits [127:64] form lane 1. Each lane is computed only from its own operands, except where another requirement names a component as the source.
- R2: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `out_data` carries the result. When `in_valid` is low at an edge, `out_valid` is low after it and `out_data` keeps its previous value.
- R3: A synchronous active-high `rst` clears both `out_valid` and `out_data` to zero.
- R4: Opcode 3 adds and opcode 4 multiplies, per lane. Both keep the low 64 bits and wrap modulo 2^64, including carries that cross from the low 32-bit component into the high one.
- R5: Opcode 1 negates in two's complement. Opcode 0 returns the absolute value. For both, the value 0x8000_0000_0000_0000 maps to itself.
- R6: Opcode 2 (set-sign) returns all ones (-1) for a negative lane, 1 for a positive lane and 0 for zero.
- R7: Opcode 5 tests equal and opcode 6 tests not-equal. A true result writes 0xFFFF_FFFF into the low component of the lane (x or z), and a false result writes zero there. The high component (y or w) is always zero.
- R8: The ordered compares produce the same result shape as R7. Opcode 7 is unsigned less-than, 8 unsigned greater-or-equal, 9 signed less-than and 10 signed greater-or-equal.
- R9: Opcode 11 is signed min, 12 unsigned min, 13 signed max and 14 unsigned max.
- R10: Opcode 15 shifts left, 16 shifts right arithmetically (sign fill) and 17 shifts right logically (zero fill). Lane 0 takes its count from component x of `src_b`, and lane 1 from component y of `src_b`. The count is ANDed with 0x3f before use.
- R11: Opcode 18 sign-extends and opcode 19 zero-extends a 32-bit value to 64 bits. Lane 0 takes component x of `src_a` and lane 1 takes component y of `src_a`.
- R12: Opcodes 20 to 31 produce an all-zero result, still delivered with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies opcode and operands for capture |
| in_op | input | 5 | Operation code |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| out_valid | output | 1 | Result strobe, one cycle after capture |
| out_data | output | 128 | Destination vector |

## Verification
The bench builds the unit with its default parameters: 32-bit components and two lanes. With these values, the 32-bit seam inside each lane can be tested directly by carries, compares that differ only in the high component, and extension sources. A count of 64 exercises the six-bit count mask. Garbage placed in components z and w of the count source and extension source shows that lane 1 really reads component y.

// File: rtl/v64_alu_pkg.sv
package v64_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ABS  = 5'd0,
    OP_NEG  = 5'd1,
    OP_SGN  = 5'd2,
    OP_ADD  = 5'd3,
    OP_MUL  = 5'd4,
    OP_EQ   = 5'd5,
    OP_NE   = 5'd6,
    OP_ULT  = 5'd7,
    OP_UGE  = 5'd8,
    OP_SLT  = 5'd9,
    OP_SGE  = 5'd10,
    OP_SMIN = 5'd11,
    OP_UMIN = 5'd12,
    OP_SMAX = 5'd13,
    OP_UMAX = 5'd14,
    OP_SHL  = 5'd15,
    OP_SRA  = 5'd16,
    OP_SRL  = 5'd17,
    OP_SEXT = 5'd18,
    OP_ZEXT = 5'd19
  } alu_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 5'd19;
endpackage

// File: rtl/v64_lane_exec.sv
module v64_lane_exec
  import v64_alu_pkg::*;
#(
  parameter int COMP_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OP_W-1:0]     op,
  input  logic [2*COMP_W-1:0] opa,
  input  logic [2*COMP_W-1:0] opb,
  input  logic [COMP_W-1:0]   cnt_src,
  input  logic [COMP_W-1:0]   ext_src,
  output logic [2*COMP_W-1:0] res
);
  localparam int LANE_W = 2 * COMP_W;
  localparam int SH_W   = $clog2(LANE_W);
  localparam logic [LANE_W-1:0] MIN_NEG = {1'b1, {(LANE_W-1){1'b0}}};

  function automatic logic [LANE_W-1:0] f_mask(input logic t);
    return {{COMP_W{1'b0}}, {COMP_W{t}}};
  endfunction

  function automatic logic [LANE_W-1:0] f_sign(input logic [LANE_W-1:0] v);
    if (v[LANE_W-1]) return '1;
    else if (v != '0) return LANE_W'(1);
    else return '0;
  endfunction

  function automatic logic [LANE_W-1:0] f_sra(input logic [LANE_W-1:0] v,
                                              input logic [SH_W-1:0] n);
    return LANE_W'($signed(v) >>> n);
  endfunction

  alu_op_e           op_e;
  logic [SH_W-1:0]   shamt;
  logic              a_neg;
  logic              eq_w;
  logic              ltu_w;
  logic              lts_w;
  logic [LANE_W-1:0] neg_w;
  logic              is_cmp;

  assign op_e   = alu_op_e'(op);
  assign shamt  = cnt_src[SH_W-1:0];
  assign a_neg  = opa[LANE_W-1];
  assign eq_w   = (opa == opb);
  assign ltu_w  = (opa < opb);
  assign lts_w  = ($signed(opa) < $signed(opb));
  assign neg_w  = (~opa) + LANE_W'(1);
  assign is_cmp = (op >= OP_EQ) && (op <= OP_SGE);

  always_comb begin
    res = '0;
    if (op <= OP_LAST) begin
      case (op_e)
        OP_ABS:  res = a_neg ? neg_w : opa;
        OP_NEG:  res = neg_w;
        OP_SGN:  res = f_sign(opa);
        OP_ADD:  res = opa + opb;
        OP_MUL:  res = opa * opb;
        OP_EQ:   res = f_mask(eq_w);
        OP_NE:   res = f_mask(!eq_w);
        OP_ULT:  res = f_mask(ltu_w);
        OP_UGE:  res = f_mask(!ltu_w);
        OP_SLT:  res = f_mask(lts_w);
        OP_SGE:  res = f_mask(!lts_w);
        OP_SMIN: res = lts_w ? opa : opb;
        OP_UMIN: res = ltu_w ? opa : opb;
        OP_SMAX: res = lts_w ? opb : opa;
        OP_UMAX: res = ltu_w ? opb : opa;
        OP_SHL:  res = opa << shamt;
        OP_SRA:  res = f_sra(opa, shamt);
        OP_SRL:  res = opa >> shamt;
        OP_SEXT: res = {{COMP_W{ext_src[COMP_W-1]}}, ext_src};
        OP_ZEXT: res = {{COMP_W{1'b0}}, ext_src};
        default: res = '0;
      endcase
    end
  end

  AST_CMP_SHAPE: assert property (@(posedge clk) disable iff (rst)
    is_cmp |-> (res[LANE_W-1:COMP_W] == '0) && ((res[COMP_W-1:0] == '0) || (&res[COMP_W-1:0]))); // R7
  AST_ORD_EXCL: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ULT) |-> !(res[0] && (opa == opb))); // R8
  AST_SGN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SGN) |-> ((res == '0) || (res == LANE_W'(1)) || (&res))); // R6
  AST_ABS_SIGN: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_ABS) && (opa != MIN_NEG)) |-> !res[LANE_W-1]); // R5
  AST_MINMAX_PICK: assert property (@(posedge clk) disable iff (rst)
    ((op >= OP_SMIN) && (op <= OP_UMAX)) |-> ((res == opa) || (res == opb))); // R9
  AST_SRL_TOP: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_SRL) && (shamt != '0)) |-> !res[LANE_W-1]); // R10
  AST_EXT_UPPER: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_SEXT) || (op == OP_ZEXT)) |-> (res[COMP_W-1:0] == ext_src)); // R11
  AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op > OP_LAST) |-> (res == '0)); // R12
endmodule

// File: rtl/v64_out_stage.sv
module v64_out_stage #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [VEC_W-1:0] nxt,
  output logic             vld,
  output logic [VEC_W-1:0] dat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      dat <= '0;
    end else begin
      vld <= cap;
      if (cap) dat <= nxt;
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    cap |=> vld); // R2
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !cap |=> !vld); // R2
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(dat)); // R2
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!vld && (dat == '0))); // R3
endmodule

// File: rtl/vec64_alu.sv
module vec64_alu
  import v64_alu_pkg::*;
#(
  parameter int COMP_W = 32,
  parameter int LANES  = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [OP_W-1:0]              in_op,
  input  logic [LANES*2*COMP_W-1:0]    src_a,
  input  logic [LANES*2*COMP_W-1:0]    src_b,
  output logic                         out_valid,
  output logic [LANES*2*COMP_W-1:0]    out_data
);
  localparam int LANE_W = 2 * COMP_W;
  localparam int VEC_W  = LANES * LANE_W;

  logic [VEC_W-1:0] lane_res;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [COMP_W-1:0] cnt_c;
    logic [COMP_W-1:0] ext_c;
    assign cnt_c = src_b[i*COMP_W +: COMP_W];
    assign ext_c = src_a[i*COMP_W +: COMP_W];

    v64_lane_exec #(.COMP_W(COMP_W)) u_exec (
      .clk     (clk),
      .rst     (rst),
      .op      (in_op),
      .opa     (src_a[i*LANE_W +: LANE_W]),
      .opb     (src_b[i*LANE_W +: LANE_W]),
      .cnt_src (cnt_c),
      .ext_src (ext_c),
      .res     (lane_res[i*LANE_W +: LANE_W])
    );
  end

  v64_out_stage #(.VEC_W(VEC_W)) u_out (
    .clk (clk),
    .rst (rst),
    .cap (in_valid),
    .nxt (lane_res),
    .vld (out_valid),
    .dat (out_data)
  );

  AST_LANE_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == OP_ADD)) |=> (out_data[LANE_W-1:0] == $past(src_a[LANE_W-1:0] + src_b[LANE_W-1:0]))); // R1
  AST_ADD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == OP_ADD) && (src_b == '0)) |=> (out_data == $past(src_a))); // R4
endmodule

// File: tb/tb_vec64_alu.sv
module tb_vec64_alu;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [4:0]   in_op = '0;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic         out_valid;
  logic [127:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  vec64_alu dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .out_data(out_data)
  );

  typedef struct packed {
    logic [4:0]   op;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] e;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
  localparam logic [63:0] TRUE = 64'h0000_0000_FFFF_FFFF;
  localparam logic [63:0] JUNK = 64'hDEAD_BEEF_1234_5678;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{5'd3,  {64'h0000_0000_FFFF_FFFF, ONES}, {64'd1, 64'd2}, {64'h0000_0001_0000_0000, 64'd1}},        // R4 add
    '{5'd4,  {64'd3, 64'h1_0000_0000}, {ONES, 64'h1_0000_0000}, {64'hFFFF_FFFF_FFFF_FFFD, 64'd0}},      // R4 mul
    '{5'd1,  {MINV, 64'd5}, 128'd0, {MINV, 64'hFFFF_FFFF_FFFF_FFFB}},                                    // R5 neg
    '{5'd0,  {MINV, 64'hFFFF_FFFF_FFFF_FFFB}, 128'd0, {MINV, 64'd5}},                                    // R5 abs
    '{5'd2,  {64'd0, 64'hFFFF_FFFF_FFFF_FFFB}, 128'd0, {64'd0, ONES}},                                   // R6
    '{5'd2,  {MINV, 64'd7}, 128'd0, {ONES, 64'd1}},                                                      // R6
    '{5'd5,  {64'h1_0000_0000, 64'd123}, {64'd0, 64'd123}, {64'd0, TRUE}},                               // R7 eq
    '{5'd6,  {64'h1_0000_0000, 64'd123}, {64'd0, 64'd123}, {TRUE, 64'd0}},                               // R7 ne
    '{5'd7,  {ONES, 64'd1}, {64'd1, ONES}, {64'd0, TRUE}},                                               // R8 ult
    '{5'd9,  {ONES, 64'd1}, {64'd1, ONES}, {TRUE, 64'd0}},                                               // R8 slt
    '{5'd8,  {ONES, 64'd1}, {64'd1, ONES}, {TRUE, 64'd0}},                                               // R8 uge
    '{5'd10, {ONES, 64'd1}, {64'd1, ONES}, {64'd0, TRUE}},                                               // R8 sge
    '{5'd11, {64'd5, 64'd1}, {64'd9, ONES}, {64'd5, ONES}},                                              // R9 smin
    '{5'd12, {64'd5, 64'd1}, {64'd9, ONES}, {64'd5, 64'd1}},                                             // R9 umin
    '{5'd13, {64'd5, 64'd1}, {64'd9, ONES}, {64'd9, 64'd1}},                                             // R9 smax
    '{5'd14, {64'd5, 64'd1}, {64'd9, ONES}, {64'd9, ONES}},                                              // R9 umax
    '{5'd15, {64'd1, 64'd1}, {JUNK, 64'h0000_003F_0000_0044}, {MINV, 64'd16}},                          // R10 shl
    '{5'd16, {64'h4000_0000_0000_0000, MINV}, {JUNK, 64'h0000_003E_0000_0004}, {64'd1, 64'hF800_0000_0000_0000}}, // R10 sra
    '{5'd17, {ONES, MINV}, {JUNK, 64'h0000_0040_0000_0004}, {ONES, 64'h0800_0000_0000_0000}},           // R10 srl
    '{5'd18, {JUNK, 64'h7FFF_FFFF_8000_0001}, 128'd0, {64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_8000_0001}}, // R11 sext
    '{5'd19, {JUNK, 64'h7FFF_FFFF_8000_0001}, 128'd0, {64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0001}}, // R11 zext
    '{5'd25, {ONES, ONES}, {ONES, ONES}, 128'd0}                                                          // R12
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic issue(input logic [4:0] op, input logic [127:0] a, input logic [127:0] b);
    in_valid = 1'b1; in_op = op; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R3: reset state
    check("R3 reset valid", {127'd0, out_valid}, 128'd0);
    check("R3 reset data", out_data, 128'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R4..R12: table walk
    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].op, TBL[i].a, TBL[i].b);
      check("R2 valid strobe", {127'd0, out_valid}, 128'd1);
      check($sformatf("R1 vector %0d op %0d", i, TBL[i].op), out_data, TBL[i].e);
    end

    // R2: idle cycle holds data, strobe low, operands ignored
    in_op = 5'd3; src_a = {ONES, ONES}; src_b = {ONES, ONES};
    @(negedge clk);
    check("R2 idle valid", {127'd0, out_valid}, 128'd0);
    check("R2 idle hold", out_data, 128'd0);

    // R2: back-to-back issue
    in_valid = 1'b1; in_op = 5'd3; src_a = {64'd10, 64'd20}; src_b = {64'd1, 64'd2};
    @(negedge clk);
    check("R2 b2b first", out_data, {64'd11, 64'd22});
    in_op = 5'd1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 b2b second", out_data, {64'hFFFF_FFFF_FFFF_FFF6, 64'hFFFF_FFFF_FFFF_FFEC});
    check("R2 b2b valid", {127'd0, out_valid}, 128'd1);
    @(negedge clk);
    check("R2 hold after b2b", out_data, {64'hFFFF_FFFF_FFFF_FFF6, 64'hFFFF_FFFF_FFFF_FFEC});

    // R5: abs of positive passes through; R6 zero lane
    issue(5'd0, {64'd0, 64'd42}, 128'd0);
    check("R5 abs positive", out_data, {64'd0, 64'd42});

    // R10: zero count on sra keeps value
    issue(5'd16, {64'd0, MINV}, {JUNK, 64'h0000_0000_0000_0040});
    check("R10 sra masked zero", out_data, {64'd0, MINV});

    // R3: reset mid-stream
    in_valid = 1'b1; in_op = 5'd3; src_a = {64'd1, 64'd1}; src_b = '0;
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b0;
    check("R3 reset mid valid", {127'd0, out_valid}, 128'd0);
    check("R3 reset mid data", out_data, 128'd0);

    finish_run();
  end
endmodule